// File: doc/BRIEF.md
# Longitudinal Parity Accumulator

This block keeps a running bytewise longitudinal parity over every data word that crosses a parallel peripheral bus, whether the word is sent or received. The parity state is a 16-bit word split into two byte lanes. Each accepted transfer XORs its data bytes, bit by bit, into the matching lane. A narrow (8-bit) transfer touches only the low lane. A wide (16-bit) transfer updates both lanes.

Software reads the state through one 8-bit window. Two control pins pick the view: the XOR of both lanes folded into one byte, the low lane alone, or the high lane alone. Software can also write the window to preset or clear the lanes.

The same accumulator serves two purposes:
- **Receive checking.** Clear the lanes, let a block plus its even-parity check byte pass, and the result is zero. Any 1 bit means a transmission error.
- **Send check-byte generation.** Clear the lanes, send the data, and read the window. The value read is the check byte to append.

The transfer input is a valid/ready stream. `xfer_ready` is high in every cycle except one in which a register write is presented. A transfer is taken only on a clock edge where both `xfer_valid` and `xfer_ready` are high. A transfer offered while `xfer_ready` is low is not taken and leaves no trace, so the source must hold or re-present it.

Top module: `lpar_accum`

## Requirements
- R1: A synchronous reset clears both lanes, so the window reads 8'h00 in all three views after the reset edge.
- R2: An accepted transfer with `xfer_wide`=1 XORs `xfer_data[7:0]` into the low lane and `xfer_data[15:8]` into the high lane. The new value is visible on the window from the cycle after the accepting edge.
- R3: An accepted transfer with `xfer_wide`=0 XORs `xfer_data[7:0]` into the low lane only. The high lane and `xfer_data[15:8]` have no effect.
- R4: With `view_split`=0, `reg_rdata` equals the low lane XOR the high lane, combinationally.
- R5: With `view_split`=1, `reg_rdata` shows the low lane when `view_high`=0 and the high lane when `view_high`=1, combinationally.
- R6: A register write (`reg_wr`=1) with `view_split`=0 loads `reg_wdata` into both lanes.
- R7: A register write with `view_split`=1 loads `reg_wdata` only into the lane that `view_high` selects, and leaves the other lane unchanged.
- R8: `xfer_ready` is 0 exactly in cycles with `reg_wr`=1. A transfer offered in such a cycle is not accepted and changes no lane, so the write wins.
- R9: After clearing, feeding the bytes 8'hCC, 8'h55 and 8'h0F gives the running low-lane values 8'hCC, 8'h99 and 8'h96. Feeding the check byte 8'h96 then returns the lane to 8'h00.
- R10: In a cycle with neither an accepted transfer nor a write, both lanes hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| xfer_valid | input | 1 | A data word is offered on `xfer_data` |
| xfer_ready | output | 1 | Accumulator can take the offered word (low during a register write) |
| xfer_data | input | 16 | Transfer data; byte 0 is the low lane, byte 1 the high lane |
| xfer_wide | input | 1 | 1: 16-bit transfer, both lanes; 0: 8-bit transfer, low lane only |
| view_split | input | 1 | 0: folded XOR view; 1: single-lane view |
| view_high | input | 1 | In single-lane view, 0 selects the low lane and 1 the high lane |
| reg_wr | input | 1 | Register write strobe for the window |
| reg_wdata | input | 8 | Byte to load on a register write |
| reg_rdata | output | 8 | Register window contents |

## Verification
The results arrive on three timings:
- **Transfers and writes (R2, R3, R6–R10)** change the lanes at the accepting clock edge. The window reflects the change from that edge on, so each is due one cycle after its stimulus. The bench drives on a falling edge and checks on the next falling edge, half a period after the update.
- **View selection (R4, R5)** is purely combinational. The bench changes the view pins between edges and samples a nanosecond later, with no clock in between.
- **`xfer_ready` (R8)** follows `reg_wr` combinationally. It is sampled in the same half cycle as the write is presented, before the edge that performs the write.

// File: rtl/lpar_pkg.sv
package lpar_pkg;
  // Width of one accumulator lane.
  localparam int unsigned LANE_W = 8;

  // Derive a selector width that is never zero.
  function automatic int unsigned sel_width(input int unsigned lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction
endpackage

// File: rtl/lpar_lane.sv
module lpar_lane #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [BW-1:0] load_val,
  input  logic          step_en,
  input  logic [BW-1:0] step_val,
  output logic [BW-1:0] acc_o
);
  logic [BW-1:0] acc_q;

  // Write beats transfer; a transfer folds its byte in by XOR.
  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (load_en) acc_q <= load_val;
    else if (step_en) acc_q <= acc_q ^ step_val;
  end

  assign acc_o = acc_q;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc_o == '0));                                           // R1
  AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en) |=> (acc_o == ($past(acc_o) ^ $past(step_val)))); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (acc_o == $past(load_val)));                          // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step_en) |=> $stable(acc_o));                       // R10
endmodule

// File: rtl/lpar_view.sv
module lpar_view #(
  parameter int unsigned BW    = 8,
  parameter int unsigned LANES = 2,
  parameter int unsigned SEL_W = 1
) (
  input  logic [LANES-1:0][BW-1:0] lanes_i,
  input  logic                     split_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [BW-1:0]            rdata_o
);
  logic [LANES:0][BW-1:0] fold;

  // Running XOR chain across all lanes.
  assign fold[0] = '0;
  for (genvar g = 0; g < LANES; g++) begin : g_fold
    assign fold[g+1] = fold[g] ^ lanes_i[g];
  end

  always_comb begin
    rdata_o = fold[LANES];
    if (split_i) begin
      rdata_o = '0;
      for (int k = 0; k < LANES; k++) begin
        if (sel_i == SEL_W'(k)) rdata_o = lanes_i[k];
      end
    end
  end
endmodule

// File: rtl/lpar_accum.sv
module lpar_accum
  import lpar_pkg::*;
#(
  parameter int unsigned LANES = 2,
  localparam int unsigned BW     = LANE_W,
  localparam int unsigned DW     = LANES * BW,
  localparam int unsigned SEL_W  = sel_width(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_valid,
  output logic             xfer_ready,
  input  logic [DW-1:0]    xfer_data,
  input  logic             xfer_wide,
  input  logic             view_split,
  input  logic [SEL_W-1:0] view_high,
  input  logic             reg_wr,
  input  logic [BW-1:0]    reg_wdata,
  output logic [BW-1:0]    reg_rdata
);
  logic                     accept;
  logic [LANES-1:0][BW-1:0] lane_acc;

  // A write owns the cycle: the stream is stalled so no byte is lost silently.
  assign xfer_ready = !reg_wr;
  assign accept     = xfer_valid && xfer_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic ld, st;
    assign ld = reg_wr && (!view_split || (view_high == SEL_W'(i)));
    if (i == 0) begin : g_base
      assign st = accept;
    end else begin : g_upper
      assign st = accept && xfer_wide;
    end

    lpar_lane #(.BW(BW)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .load_en  (ld),
      .load_val (reg_wdata),
      .step_en  (st),
      .step_val (xfer_data[i*BW +: BW]),
      .acc_o    (lane_acc[i])
    );
  end

  lpar_view #(.BW(BW), .LANES(LANES), .SEL_W(SEL_W)) u_view (
    .lanes_i (lane_acc),
    .split_i (view_split),
    .sel_i   (view_high),
    .rdata_o (reg_rdata)
  );

  AST_WRITE_STALLS: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> !xfer_ready);                                          // R8
  AST_STALL_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && reg_wr && view_split && view_high == '0)
      |=> $stable(lane_acc[LANES-1]));                                // R8
  AST_NARROW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (accept && !xfer_wide) |=> $stable(lane_acc[LANES-1]));           // R3
endmodule

// File: tb/lpar_accum_tb.sv
`timescale 1ns/1ps
module lpar_accum_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        xfer_valid;
  logic        xfer_ready;
  logic [15:0] xfer_data;
  logic        xfer_wide;
  logic        view_split;
  logic [0:0]  view_high;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] m_lo, m_hi;

  always #2.5 clk = ~clk;

  lpar_accum u_dut (
    .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_data(xfer_data), .xfer_wide(xfer_wide), .view_split(view_split),
    .view_high(view_high), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // Walk all three views between edges and compare with the model.
  task automatic check_views(input string req);
    view_split = 1'b0; view_high = 1'b0; #1;
    check({req, "/R4 fold"}, reg_rdata, m_lo ^ m_hi);
    view_split = 1'b1; view_high = 1'b0; #1;
    check({req, "/R5 low"}, reg_rdata, m_lo);
    view_high = 1'b1; #1;
    check({req, "/R5 high"}, reg_rdata, m_hi);
  endtask

  task automatic xfer(input logic [15:0] d, input logic wide);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_data = d; xfer_wide = wide;
    @(negedge clk);
    xfer_valid = 1'b0;
    m_lo = m_lo ^ d[7:0];
    if (wide) m_hi = m_hi ^ d[15:8];
  endtask

  // Register write; optionally a transfer is offered in the same cycle.
  task automatic wr(input logic split, input logic sel, input logic [7:0] v,
                    input logic with_xfer);
    @(negedge clk);
    view_split = split; view_high = sel; reg_wr = 1'b1; reg_wdata = v;
    xfer_valid = with_xfer; xfer_data = 16'hA5C3; xfer_wide = 1'b1;
    #1;
    check("R8 ready low on write", {7'd0, xfer_ready}, 8'h00);
    @(negedge clk);
    reg_wr = 1'b0; xfer_valid = 1'b0;
    if (!split) begin m_lo = v; m_hi = v; end
    else if (sel) m_hi = v;
    else          m_lo = v;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; xfer_valid = 1'b0; xfer_data = '0; xfer_wide = 1'b0;
    view_split = 1'b0; view_high = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    m_lo = '0; m_hi = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_views("R1 reset");
    #1;
    check("R8 ready idle", {7'd0, xfer_ready}, 8'h01);

    // R9: worked example, receive then send.
    xfer(16'hFFCC, 1'b0); view_split = 1'b1; view_high = 1'b0; #1;
    check("R9 step1", reg_rdata, 8'hCC);
    xfer(16'h0055, 1'b0); view_split = 1'b1; view_high = 1'b0; #1;
    check("R9 step2", reg_rdata, 8'h99);
    xfer(16'h330F, 1'b0); view_split = 1'b1; view_high = 1'b0; #1;
    check("R9 step3", reg_rdata, 8'h96);
    xfer(16'h0096, 1'b0); view_split = 1'b1; view_high = 1'b0; #1;
    check("R9 check byte", reg_rdata, 8'h00);
    check_views("R3 narrow high untouched");

    // R3: sweep every low byte on narrow transfers, high byte varies.
    for (int i = 0; i < 256; i++) begin
      xfer({8'(i * 7 + 1), 8'(i)}, 1'b0);
      check_views("R3 narrow sweep");
    end

    // R2: wide transfers driven by an LFSR.
    lfsr = 16'hACE1;
    for (int i = 0; i < 256; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      xfer(lfsr, 1'b1);
      check_views("R2 wide sweep");
    end

    // R10: idle cycles hold state.
    repeat (5) @(negedge clk);
    check_views("R10 idle hold");

    // R6/R7: writes in each view, with and without a colliding transfer.
    for (int v = 0; v < 256; v += 17) begin
      wr(1'b0, 1'b0, 8'(v), v[0]);
      check_views("R6 fold write");
      wr(1'b1, 1'b0, 8'(v ^ 8'h3C), 1'b1);
      check_views("R7 low write / R8 collision");
      wr(1'b1, 1'b1, 8'(v + 8'h81), v[1]);
      check_views("R7 high write / R8 collision");
    end

    // R9 send side: clear, send, read check byte, then append it.
    wr(1'b0, 1'b0, 8'h00, 1'b0);
    xfer(16'h00CC, 1'b0); xfer(16'h0055, 1'b0); xfer(16'h000F, 1'b0);
    view_split = 1'b1; view_high = 1'b0; #1;
    check("R9 send check byte", reg_rdata, 8'h96);
    xfer(16'h0096, 1'b0);
    view_split = 1'b0; #1;
    check("R9 send verify", reg_rdata, 8'h00);

    // R1: reset mid-run clears everything.
    xfer(16'h1234, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_lo = '0; m_hi = '0;
    check_views("R1 mid reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule